// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block turns one programmed DMA channel setup into the stream of read and write beats that move the data. It takes a source and a destination start address, a transfer count, a width code for each side, a burst-length code, an addressing mode for each side and a per-side handshake flag. After a start pulse it issues a burst of read beats and then the write beats that carry the same bytes. It repeats this until the count is used up.

Each beat is a valid/ready request that carries an address and a size code. The data path and the bus protocol live outside the block. A side set to handshake mode waits for a level request from its peripheral before each burst. It returns a one-cycle acknowledge when that side's part of the burst is finished. The channel reports a clean finish, a rejected setup or an abort with a single-cycle pulse on one of three outputs, and then goes back to idle.

Top module: `chan_addr_seq`

## Requirements
- R1: A width code w (0 to 5) means 2^w bytes per beat, and it is presented unchanged on `rd_size` / `wr_size`. A burst code b (0 to 10) means 2^b source-width beats per burst.
- R2: The first read address is `src_addr`. After each accepted read, address control 0 adds 2^sw bytes, 1 subtracts 2^sw bytes and 2 keeps the address.
- R3: The first write address is `dst_addr`. After each accepted write, the destination address moves by 2^dw bytes with the same three control codes.
- R4: `xfer_count` counts source-width beats. Each burst is 2^b reads followed by 2^(b+sw-dw) writes. Bursts repeat until the count is consumed, and no beat is issued beyond it.
- R5: A read or write request that is not yet accepted stays valid and keeps its address until ready is seen.
- R6: A start is rejected if any of these holds: a width code above 5, a burst code above 10, an address control of 3, `src_addr` or `dst_addr` not a multiple of 2^(b+sw) bytes, `xfer_count` not a multiple of 2^b, or a destination width larger than 2^(b+sw) bytes. A rejected start gives `error` high for one cycle, in the cycle after start, and issues no request.
- R7: With `src_hs`=1, the reads of each burst begin only after `src_req` is seen high. `src_ack` pulses for one cycle in the cycle after the last read of a burst is accepted.
- R8: With `dst_hs`=1, the writes of each burst begin only after `dst_req` is seen high. `dst_ack` pulses for one cycle in the cycle after the last write of a burst is accepted.
- R9: `done` is high for exactly one cycle, in the cycle after the final write is accepted, and the channel is idle from then on. Out of reset no request or status output is active.
- R10: A legal start with `xfer_count` = 0 gives `done` in the cycle after start and issues no request.
- R11: An `abort` pulse ends the transfer at the next beat acceptance, or at once while the channel waits for a handshake request. `aborted` is then high for one cycle in the following cycle, no further request follows, and `done` is not raised.
- R12: A start while a transfer is running is ignored and does not change the running sequence.
- R13: A side in normal mode (handshake flag 0) never raises its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a transfer with the setup on the configuration inputs |
| abort | input | 1 | Stop the running transfer at the next beat boundary |
| src_addr | input | AW | Source start address |
| dst_addr | input | AW | Destination start address |
| xfer_count | input | CW | Number of source-width beats to move |
| src_width | input | 3 | Source width code |
| dst_width | input | 3 | Destination width code |
| burst_code | input | 4 | Burst length code |
| src_ctl | input | 2 | Source address control (0 up, 1 down, 2 fixed) |
| dst_ctl | input | 2 | Destination address control (0 up, 1 down, 2 fixed) |
| src_hs | input | 1 | Source handshake mode |
| dst_hs | input | 1 | Destination handshake mode |
| src_req | input | 1 | Source peripheral request |
| dst_req | input | 1 | Destination peripheral request |
| rd_valid | output | 1 | Read beat request |
| rd_ready | input | 1 | Read beat accepted |
| rd_addr | output | AW | Read beat address |
| rd_size | output | 3 | Read beat width code |
| wr_valid | output | 1 | Write beat request |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | AW | Write beat address |
| wr_size | output | 3 | Write beat width code |
| src_ack | output | 1 | Source burst finished pulse |
| dst_ack | output | 1 | Destination burst finished pulse |
| done | output | 1 | Transfer completed pulse |
| error | output | 1 | Setup rejected pulse |
| aborted | output | 1 | Transfer aborted pulse |

## Verification
The hardest case to reach is an abort that arrives in exactly the cycle when a beat is accepted, in the middle of a burst. The result is only meaningful if the number of beats already moved is known. The stimulus holds ready high so that every cycle of the read phase accepts one beat. It then pulses abort on a chosen cycle that is not the end of a burst, and checks that the pulse and the end of all requests come one cycle later. A second abort lands while the source side waits for a request that is never given. Random ready patterns across incrementing, decrementing and fixed addressing, including the largest burst code, exercise the held-request rule.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int MAX_WIDTH_CODE = 5;
    localparam int MAX_BURST_CODE = 10;
    localparam int RBW = MAX_BURST_CODE + 1;
    localparam int WBW = MAX_BURST_CODE + MAX_WIDTH_CODE + 1;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SWAIT = 3'd1,
        ST_RD    = 3'd2,
        ST_DWAIT = 3'd3,
        ST_WR    = 3'd4
    } seq_state_e;

    localparam logic [1:0] AC_INC = 2'd0;
    localparam logic [1:0] AC_DEC = 2'd1;
    localparam logic [1:0] AC_FIX = 2'd2;
endpackage

// File: rtl/seq_cfg_check.sv
module seq_cfg_check
    import seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [CW-1:0] count,
    input  logic [2:0]    sw,
    input  logic [2:0]    dw,
    input  logic [3:0]    blen,
    input  logic [1:0]    sctl,
    input  logic [1:0]    dctl,
    output logic          bad
);
    logic [4:0]    span_log;
    logic [AW-1:0] amask;
    logic [CW-1:0] cmask;
    logic          code_bad;
    logic          align_bad;
    logic          fit_bad;

    always_comb begin
        span_log  = 5'(blen) + 5'(sw);
        amask     = ~({AW{1'b1}} << span_log);
        cmask     = ~({CW{1'b1}} << blen);
        code_bad  = (sw > 3'(MAX_WIDTH_CODE)) || (dw > 3'(MAX_WIDTH_CODE)) ||
                    (blen > 4'(MAX_BURST_CODE)) ||
                    (sctl == 2'd3) || (dctl == 2'd3);
        align_bad = ((src_addr & amask) != '0) || ((dst_addr & amask) != '0) ||
                    ((count & cmask) != '0);
        fit_bad   = 5'(dw) > span_log;
        bad       = code_bad || align_bad || fit_bad;
    end
endmodule

// File: rtl/seq_burst_size.sv
module seq_burst_size
    import seq_pkg::*;
(
    input  logic [2:0]     sw,
    input  logic [2:0]     dw,
    input  logic [3:0]     blen,
    output logic [RBW-1:0] rd_beats,
    output logic [WBW-1:0] wr_beats
);
    logic [4:0] span_log;
    logic [4:0] wexp;

    always_comb begin
        span_log = 5'(blen) + 5'(sw);
        wexp     = (5'(dw) > span_log) ? 5'd0 : span_log - 5'(dw);
        rd_beats = RBW'(1) << blen;
        wr_beats = WBW'(1) << wexp;
    end
endmodule

// File: rtl/seq_addr_step.sv
module seq_addr_step
    import seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [2:0]    code,
    input  logic [1:0]    ctl,
    output logic [AW-1:0] next
);
    logic [AW-1:0] step;

    always_comb begin
        step = AW'(1) << code;
        case (ctl)
            AC_INC:  next = addr + step;
            AC_DEC:  next = addr - step;
            default: next = addr;
        endcase
    end
endmodule

// File: rtl/chan_addr_seq.sv
module chan_addr_seq
    import seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [CW-1:0] xfer_count,
    input  logic [2:0]    src_width,
    input  logic [2:0]    dst_width,
    input  logic [3:0]    burst_code,
    input  logic [1:0]    src_ctl,
    input  logic [1:0]    dst_ctl,
    input  logic          src_hs,
    input  logic          dst_hs,
    input  logic          src_req,
    input  logic          dst_req,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [AW-1:0] rd_addr,
    output logic [2:0]    rd_size,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [2:0]    wr_size,
    output logic          src_ack,
    output logic          dst_ack,
    output logic          done,
    output logic          error,
    output logic          aborted
);
    typedef struct packed {
        seq_state_e     state;
        logic [AW-1:0]  sa;
        logic [AW-1:0]  da;
        logic [CW-1:0]  rem;
        logic [RBW-1:0] rcnt;
        logic [WBW-1:0] wcnt;
        logic [2:0]     sw;
        logic [2:0]     dw;
        logic [3:0]     blen;
        logic [1:0]     sctl;
        logic [1:0]     dctl;
        logic           shs;
        logic           dhs;
        logic           abort_pend;
        logic           done;
        logic           error;
        logic           aborted;
        logic           sack;
        logic           dack;
    } seq_regs_t;

    seq_regs_t q, d;

    logic           cfg_bad;
    logic [2:0]     sz_sw, sz_dw;
    logic [3:0]     sz_blen;
    logic [RBW-1:0] rd_beats;
    logic [WBW-1:0] wr_beats;
    logic [AW-1:0]  sa_next, da_next;
    logic           abort_now;
    logic           idle;

    assign idle    = (q.state == ST_IDLE);
    assign sz_sw   = idle ? src_width  : q.sw;
    assign sz_dw   = idle ? dst_width  : q.dw;
    assign sz_blen = idle ? burst_code : q.blen;

    seq_cfg_check #(.AW(AW), .CW(CW)) u_check (
        .src_addr (src_addr),
        .dst_addr (dst_addr),
        .count    (xfer_count),
        .sw       (src_width),
        .dw       (dst_width),
        .blen     (burst_code),
        .sctl     (src_ctl),
        .dctl     (dst_ctl),
        .bad      (cfg_bad)
    );

    seq_burst_size u_size (
        .sw       (sz_sw),
        .dw       (sz_dw),
        .blen     (sz_blen),
        .rd_beats (rd_beats),
        .wr_beats (wr_beats)
    );

    seq_addr_step #(.AW(AW)) u_src_step (
        .addr (q.sa),
        .code (q.sw),
        .ctl  (q.sctl),
        .next (sa_next)
    );

    seq_addr_step #(.AW(AW)) u_dst_step (
        .addr (q.da),
        .code (q.dw),
        .ctl  (q.dctl),
        .next (da_next)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.error   = 1'b0;
        d.aborted = 1'b0;
        d.sack    = 1'b0;
        d.dack    = 1'b0;
        abort_now = q.abort_pend | abort;

        case (q.state)
            ST_IDLE: begin
                d.abort_pend = 1'b0;
                if (start) begin
                    if (cfg_bad) begin
                        d.error = 1'b1;
                    end else if (xfer_count == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.sa    = src_addr;
                        d.da    = dst_addr;
                        d.rem   = xfer_count;
                        d.sw    = src_width;
                        d.dw    = dst_width;
                        d.blen  = burst_code;
                        d.sctl  = src_ctl;
                        d.dctl  = dst_ctl;
                        d.shs   = src_hs;
                        d.dhs   = dst_hs;
                        d.rcnt  = rd_beats;
                        d.state = src_hs ? ST_SWAIT : ST_RD;
                    end
                end
            end
            ST_SWAIT: begin
                if (abort_now) begin
                    d.state   = ST_IDLE;
                    d.aborted = 1'b1;
                end else if (src_req) begin
                    d.state = ST_RD;
                end
            end
            ST_RD: begin
                d.abort_pend = abort_now;
                if (rd_ready) begin
                    d.sa = sa_next;
                    if (q.rcnt == RBW'(1)) begin
                        d.sack  = q.shs;
                        d.wcnt  = wr_beats;
                        d.state = q.dhs ? ST_DWAIT : ST_WR;
                    end else begin
                        d.rcnt = q.rcnt - RBW'(1);
                    end
                    if (abort_now) begin
                        d.state   = ST_IDLE;
                        d.aborted = 1'b1;
                    end
                end
            end
            ST_DWAIT: begin
                if (abort_now) begin
                    d.state   = ST_IDLE;
                    d.aborted = 1'b1;
                end else if (dst_req) begin
                    d.state = ST_WR;
                end
            end
            ST_WR: begin
                d.abort_pend = abort_now;
                if (wr_ready) begin
                    d.da = da_next;
                    if (q.wcnt == WBW'(1)) begin
                        d.dack = q.dhs;
                        d.rem  = q.rem - CW'(rd_beats);
                        d.rcnt = rd_beats;
                        if (q.rem == CW'(rd_beats)) begin
                            d.state = ST_IDLE;
                            d.done  = 1'b1;
                        end else begin
                            d.state = q.shs ? ST_SWAIT : ST_RD;
                        end
                    end else begin
                        d.wcnt = q.wcnt - WBW'(1);
                    end
                    if (abort_now) begin
                        d.state   = ST_IDLE;
                        d.done    = 1'b0;
                        d.aborted = 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_valid = (q.state == ST_RD);
    assign rd_addr  = q.sa;
    assign rd_size  = q.sw;
    assign wr_valid = (q.state == ST_WR);
    assign wr_addr  = q.da;
    assign wr_size  = q.dw;
    assign src_ack  = q.sack;
    assign dst_ack  = q.dack;
    assign done     = q.done;
    assign error    = q.error;
    assign aborted  = q.aborted;

    // R5: an unaccepted read request is held with the same address
    a_r5_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !abort && !q.abort_pend) |=> (rd_valid && $stable(rd_addr)));

    // R5: an unaccepted write request is held with the same address
    a_r5_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready && !abort && !q.abort_pend) |=> (wr_valid && $stable(wr_addr)));

    // R6: a rejected start raises error and no request
    a_r6_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle && cfg_bad) |=> (error && !rd_valid && !wr_valid));

    // R9: done only follows an accepted write
    a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(start)) |-> $past(wr_valid && wr_ready));

    // R11: at most one ending pulse at a time
    a_r11_one_ending: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, error, aborted}));

    // R7: source acknowledge only after an accepted read
    a_r7_sack_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        src_ack |-> $past(rd_valid && rd_ready));

    // R2: fixed source address does not move after a beat
    a_r2_fixed_src: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && q.sctl == AC_FIX) |=> $stable(rd_addr));
endmodule

// File: tb/tb_chan_addr_seq.sv
module tb_chan_addr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int CW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, abort = 1'b0;
    logic [AW-1:0] src_addr = '0, dst_addr = '0;
    logic [CW-1:0] xfer_count = '0;
    logic [2:0]    src_width = '0, dst_width = '0;
    logic [3:0]    burst_code = '0;
    logic [1:0]    src_ctl = '0, dst_ctl = '0;
    logic          src_hs = 1'b0, dst_hs = 1'b0, src_req = 1'b0, dst_req = 1'b0;
    logic          rd_valid, wr_valid, rd_ready = 1'b0, wr_ready = 1'b0;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [2:0]    rd_size, wr_size;
    logic          src_ack, dst_ack, done, error, aborted;

    chan_addr_seq #(.AW(AW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .src_addr(src_addr), .dst_addr(dst_addr), .xfer_count(xfer_count),
        .src_width(src_width), .dst_width(dst_width), .burst_code(burst_code),
        .src_ctl(src_ctl), .dst_ctl(dst_ctl), .src_hs(src_hs), .dst_hs(dst_hs),
        .src_req(src_req), .dst_req(dst_req),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_size(rd_size),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_size(wr_size),
        .src_ack(src_ack), .dst_ack(dst_ack), .done(done), .error(error), .aborted(aborted)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_rd[$];
    logic [31:0] exp_wr[$];
    int rpb = 1, wpb = 1, rd_seen = 0, wr_seen = 0;
    bit m_shs = 0, m_dhs = 0, mon_on = 0, rdy_rand = 0;
    logic [2:0] m_sw = '0, m_dw = '0;
    bit exp_done_nx = 0, exp_sack_nx = 0, exp_dack_nx = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] a, input logic [1:0] c, input logic [2:0] w);
        case (c)
            2'd0:    return a + (32'd1 << w);
            2'd1:    return a - (32'd1 << w);
            default: return a;
        endcase
    endfunction

    task automatic prep(input logic [31:0] s, input logic [31:0] dd, input int cnt,
                        input logic [2:0] sw, input logic [2:0] dw, input int b,
                        input logic [1:0] sc, input logic [1:0] dc, input bit shs, input bit dhs);
        logic [31:0] a;
        int nw;
        exp_rd.delete();
        exp_wr.delete();
        a = s;
        for (int i = 0; i < cnt; i++) begin exp_rd.push_back(a); a = nxt(a, sc, sw); end
        nw = (cnt << sw) >> dw;
        a = dd;
        for (int i = 0; i < nw; i++) begin exp_wr.push_back(a); a = nxt(a, dc, dw); end
        rpb = 1 << b;
        wpb = (1 << (b + sw)) >> dw;
        rd_seen = 0; wr_seen = 0;
        m_sw = sw; m_dw = dw; m_shs = shs; m_dhs = dhs;
    endtask

    task automatic kick(input logic [31:0] s, input logic [31:0] dd, input int cnt,
                        input logic [2:0] sw, input logic [2:0] dw, input logic [3:0] b,
                        input logic [1:0] sc, input logic [1:0] dc, input bit shs, input bit dhs);
        @(negedge clk);
        src_addr = s; dst_addr = dd; xfer_count = CW'(cnt);
        src_width = sw; dst_width = dw; burst_code = b;
        src_ctl = sc; dst_ctl = dc; src_hs = shs; dst_hs = dhs;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 60000) begin @(negedge clk); t++; end
        check(done == 1'b1, "R9 done reached", done, 1);
        check(exp_rd.size() == 0 && exp_wr.size() == 0, "R4 all beats issued",
              exp_rd.size() + exp_wr.size(), 0);
        @(negedge clk);
    endtask

    task automatic expect_reject(input string tag, input logic [31:0] s, input logic [31:0] dd,
                                 input int cnt, input logic [2:0] sw, input logic [2:0] dw,
                                 input logic [3:0] b, input logic [1:0] sc, input logic [1:0] dc);
        kick(s, dd, cnt, sw, dw, b, sc, dc, 1'b0, 1'b0);
        check(error == 1'b1, tag, error, 1);
        check(!rd_valid && !wr_valid && !done, {tag, " quiet"}, {rd_valid, wr_valid, done}, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!rd_valid && !wr_valid && !error, {tag, " stays idle"}, {rd_valid, wr_valid, error}, 0);
        end
    endtask

    // Reference model: compares every cycle at the falling edge and drives ready
    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_on) begin
                check(done == exp_done_nx, "R9 done timing", done, exp_done_nx);
                check(src_ack == exp_sack_nx, m_shs ? "R7 src_ack timing" : "R13 src_ack quiet",
                      src_ack, exp_sack_nx);
                check(dst_ack == exp_dack_nx, m_dhs ? "R8 dst_ack timing" : "R13 dst_ack quiet",
                      dst_ack, exp_dack_nx);
                check(!error && !aborted, "R11 no stray ending", {error, aborted}, 0);
            end
            exp_done_nx = 0; exp_sack_nx = 0; exp_dack_nx = 0;
            rd_ready = rdy_rand ? (($urandom % 3) != 0) : 1'b1;
            wr_ready = rdy_rand ? (($urandom % 3) != 0) : 1'b1;
            if (rd_valid && rd_ready) begin
                if (exp_rd.size() == 0) check(1'b0, "R4 extra read", rd_addr, 0);
                else begin
                    logic [31:0] e;
                    e = exp_rd.pop_front();
                    check(rd_addr == e, "R2 read address", rd_addr, e);
                    check(rd_size == m_sw, "R1 read size", rd_size, m_sw);
                    rd_seen++;
                    if (rd_seen % rpb == 0) exp_sack_nx = m_shs;
                end
            end
            if (wr_valid && wr_ready) begin
                if (exp_wr.size() == 0) check(1'b0, "R4 extra write", wr_addr, 0);
                else begin
                    logic [31:0] e;
                    e = exp_wr.pop_front();
                    check(wr_addr == e, "R3 write address", wr_addr, e);
                    check(wr_size == m_dw, "R1 write size", wr_size, m_dw);
                    wr_seen++;
                    if (wr_seen % wpb == 0) exp_dack_nx = m_dhs;
                    if (exp_wr.size() == 0) exp_done_nx = 1;
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!rd_valid && !wr_valid && !done && !error && !aborted && !src_ack && !dst_ack,
              "R9 reset idle", {rd_valid, wr_valid, done, error, aborted, src_ack, dst_ack}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4: increment both sides, word beats, bursts of 4
        mon_on = 1; rdy_rand = 0;
        prep(32'h1000, 32'h8000, 8, 3'd2, 3'd2, 2, 2'd0, 2'd0, 0, 0);
        kick(32'h1000, 32'h8000, 8, 3'd2, 3'd2, 4'd2, 2'd0, 2'd0, 1'b0, 1'b0);
        wait_done();

        // R2 R3 R5: decrement source, fixed destination, random ready
        rdy_rand = 1;
        prep(32'h2000, 32'h4000, 16, 3'd0, 3'd1, 3, 2'd1, 2'd2, 0, 0);
        kick(32'h2000, 32'h4000, 16, 3'd0, 3'd1, 4'd3, 2'd1, 2'd2, 1'b0, 1'b0);
        wait_done();

        // R1 R4: fixed wide source, byte destination, single-beat bursts
        prep(32'h0100, 32'h0300, 4, 3'd3, 3'd0, 0, 2'd2, 2'd0, 0, 0);
        kick(32'h0100, 32'h0300, 4, 3'd3, 3'd0, 4'd0, 2'd2, 2'd0, 1'b0, 1'b0);
        wait_done();

        // R1 R4: largest burst code, widest destination
        prep(32'h10000, 32'h20000, 2048, 3'd0, 3'd5, 10, 2'd0, 2'd0, 0, 0);
        kick(32'h10000, 32'h20000, 2048, 3'd0, 3'd5, 4'd10, 2'd0, 2'd0, 1'b0, 1'b0);
        wait_done();

        // R12: a second start during a transfer is ignored
        prep(32'h3000, 32'h5000, 16, 3'd1, 3'd1, 2, 2'd0, 2'd1, 0, 0);
        kick(32'h3000, 32'h5000, 16, 3'd1, 3'd1, 4'd2, 2'd0, 2'd1, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        src_addr = 32'h7700; dst_addr = 32'h7900; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(1'b1, "R12 start while busy issued", 1, 1);
        wait_done();

        // R7 R8: handshake on both sides
        rdy_rand = 0;
        prep(32'h6000, 32'h9000, 8, 3'd2, 3'd1, 2, 2'd0, 2'd0, 1, 1);
        kick(32'h6000, 32'h9000, 8, 3'd2, 3'd1, 4'd2, 2'd0, 2'd0, 1'b1, 1'b1);
        for (int i = 0; i < 10; i++) begin
            check(!rd_valid, "R7 reads wait for request", rd_valid, 0);
            @(negedge clk);
        end
        src_req = 1'b1;
        while (rd_seen < rpb) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(!wr_valid, "R8 writes wait for request", wr_valid, 0);
        end
        dst_req = 1'b1;
        wait_done();
        src_req = 1'b0; dst_req = 1'b0;

        // R6: rejected setups
        mon_on = 0;
        expect_reject("R6 source misaligned", 32'h1004, 32'h2000, 4, 3'd2, 3'd2, 4'd2, 2'd0, 2'd0);
        expect_reject("R6 destination misaligned", 32'h1000, 32'h2008, 4, 3'd2, 3'd2, 4'd2, 2'd0, 2'd0);
        expect_reject("R6 count not whole bursts", 32'h1000, 32'h2000, 6, 3'd2, 3'd2, 4'd2, 2'd0, 2'd0);
        expect_reject("R6 burst code 11", 32'h0, 32'h0, 0, 3'd0, 3'd0, 4'd11, 2'd0, 2'd0);
        expect_reject("R6 width code 6", 32'h0, 32'h0, 4, 3'd6, 3'd0, 4'd0, 2'd0, 2'd0);
        expect_reject("R6 address control 3", 32'h0, 32'h0, 4, 3'd0, 3'd0, 4'd0, 2'd3, 2'd0);
        expect_reject("R6 destination wider than burst", 32'h0, 32'h0, 4, 3'd1, 3'd3, 4'd1, 2'd0, 2'd0);

        // R10: zero count finishes at once
        kick(32'h40, 32'h80, 0, 3'd2, 3'd2, 4'd1, 2'd0, 2'd0, 1'b0, 1'b0);
        check(done == 1'b1 && !rd_valid && !wr_valid, "R10 zero count done", {done, rd_valid, wr_valid}, 3'b100);
        @(negedge clk);
        check(done == 1'b0, "R10 done single cycle", done, 0);

        // R11: abort on a mid-burst read acceptance
        prep(32'h1000, 32'h8000, 16, 3'd2, 3'd2, 2, 2'd0, 2'd0, 0, 0);
        kick(32'h1000, 32'h8000, 16, 3'd2, 3'd2, 4'd2, 2'd0, 2'd0, 1'b0, 1'b0);
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check(aborted == 1'b1 && !done, "R11 aborted pulse", {aborted, done}, 2'b10);
        check(!rd_valid && !wr_valid, "R11 requests stop", {rd_valid, wr_valid}, 0);
        check(rd_seen == 2, "R11 beats before abort", rd_seen, 2);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(!rd_valid && !wr_valid && !done && !aborted, "R11 stays idle",
                  {rd_valid, wr_valid, done, aborted}, 0);
        end

        // R11: abort while waiting for a source request
        prep(32'h1000, 32'h8000, 4, 3'd2, 3'd2, 2, 2'd0, 2'd0, 1, 0);
        kick(32'h1000, 32'h8000, 4, 3'd2, 3'd2, 4'd2, 2'd0, 2'd0, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check(aborted == 1'b1 && !rd_valid, "R11 abort in wait", {aborted, rd_valid}, 2'b10);
        @(negedge clk);
        check(!aborted && !rd_valid, "R11 abort single cycle", {aborted, rd_valid}, 0);
        exp_rd.delete(); exp_wr.delete();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule